// File: doc/BRIEF.md
# Operand Effective Address Sequencer

This unit works out where an 8-bit processor's instruction operand lives. The instruction sequencer pulses `start` with a 4-bit mode code, the program counter (already pointing at the first byte after the opcode) and the two index registers. The unit then fetches the operand bytes it needs, and for the pointer modes the pointer bytes too, through a plain synchronous byte-read port. It returns the 16-bit effective address, the advanced program counter and a flag that marks a page crossing, all qualified by a one-cycle `done` pulse.

The memory port is simple. In one cycle the unit drives `mem_addr` and raises `mem_rd`. The byte comes back on `mem_rdata` in the following cycle and is captured at the end of that cycle. Each byte therefore costs a request state and a wait state.

The states are ST_IDLE, ST_OPL_REQ, ST_OPL_WAIT, ST_OPH_REQ, ST_OPH_WAIT, ST_PTL_REQ, ST_PTL_WAIT, ST_PTH_REQ, ST_PTH_WAIT, ST_CALC and ST_DONE. The transitions are:
- ST_IDLE to ST_CALC when start arrives with the immediate mode or an unused code.
- ST_IDLE to ST_OPL_REQ when start arrives with any other mode.
- Each *_REQ state to its *_WAIT state.
- ST_OPL_WAIT to ST_OPH_REQ for two-byte operands, to ST_PTL_REQ for the two zero-page pointer modes, and to ST_CALC otherwise.
- ST_OPH_WAIT to ST_PTL_REQ for the jump-vector mode, and to ST_CALC otherwise.
- ST_PTL_WAIT to ST_PTH_REQ, and ST_PTH_WAIT to ST_CALC.
- ST_CALC to ST_DONE, and ST_DONE to ST_IDLE.

Top module: `oau_top`

## Requirements
- R1: After an active-high synchronous reset, `done`, `page_cross`, `mem_rd`, `ea` and `pc_out` are all 0.
- R2: Mode 0 (immediate) returns `ea` equal to the program counter and `pc_out` equal to the program counter plus 1, with no reads. `done` rises 2 clock edges after the start edge.
- R3: Mode 1 (zero page) returns `ea` = {00, operand}. Modes 2 and 3 add X or Y respectively to the operand modulo 256. All three return `pc_out` = PC+1 and `page_cross` 0, and `done` comes 4 edges after start.
- R4: Mode 4 (absolute) reads the low byte at PC and the high byte at PC+1, in that order. It returns that address with `pc_out` = PC+2, and `done` comes 6 edges after start.
- R5: Modes 5 and 6 add X or Y respectively to the 16-bit absolute base. `page_cross` is 1 exactly when the upper byte of the result differs from the upper byte of the base.
- R6: Mode 7 forms P = (operand + X) mod 256. It reads the pointer low byte at {00,P} and the high byte at {00,(P+1) mod 256}. It returns the pointer with `page_cross` 0 and `pc_out` = PC+1, and `done` comes 8 edges after start.
- R7: Mode 8 reads a pointer at {00,operand} and {00,(operand+1) mod 256}, then adds Y. `page_cross` compares the upper bytes of the pointer and the result.
- R8: Mode 9 (jump vector) takes the 16-bit vector V from PC and PC+1. It reads the target low byte at V and the high byte at {V[15:8], (V[7:0]+1) mod 256}, so a vector ending in FF wraps inside its page. It returns `pc_out` = PC+2, and `done` comes 10 edges after start.
- R9: Mode 10 (relative) returns (PC+1) plus the sign-extended operand byte and `pc_out` = PC+1. `page_cross` is 1 when the upper bytes of PC+1 and the target differ.
- R10: Mode codes 11 to 15 finish with no reads. They return `ea` 0, `pc_out` equal to the input PC and `page_cross` 0, and `done` comes 2 edges after start.
- R11: `done` is high for exactly one cycle per operation. `start` while the unit is busy has no effect on the running operation and does not queue a second one.
- R12: Every byte is fetched with a single one-cycle `mem_rd` strobe at the stated address. Two strobes are never back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an address computation (sampled only when idle) |
| mode | input | 4 | Addressing mode code |
| pc_in | input | 16 | Program counter pointing at the first operand byte |
| x_idx | input | 8 | X index value |
| y_idx | input | 8 | Y index value |
| mem_addr | output | 16 | Read address |
| mem_rd | output | 1 | Read strobe, one cycle per byte |
| mem_rdata | input | 8 | Read data, valid the cycle after the strobe |
| ea | output | 16 | Effective address |
| page_cross | output | 1 | Page-crossing indication |
| pc_out | output | 16 | Advanced program counter |
| done | output | 1 | One-cycle completion pulse |

## Verification
A state machine that takes the wrong path shows up on the memory port before it shows up anywhere else. The `mem_rd` address sequence goes wrong one cycle after the bad transition, or the read count differs, and the bench logs both. A captured byte stored in the wrong register, or a wrong pointer page, appears in `ea` at the `done` pulse, which the bench samples at the exact edge count each mode allows. An extra or missing state moves `done` by at least one cycle, and the latency checks catch that.

// File: rtl/oau_pkg.sv
package oau_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        M_IMM  = 4'd0,
        M_ZP   = 4'd1,
        M_ZPX  = 4'd2,
        M_ZPY  = 4'd3,
        M_ABS  = 4'd4,
        M_ABSX = 4'd5,
        M_ABSY = 4'd6,
        M_INDX = 4'd7,
        M_INDY = 4'd8,
        M_IND  = 4'd9,
        M_REL  = 4'd10
    } mode_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPL_REQ,
        ST_OPL_WAIT,
        ST_OPH_REQ,
        ST_OPH_WAIT,
        ST_PTL_REQ,
        ST_PTL_WAIT,
        ST_PTH_REQ,
        ST_PTH_WAIT,
        ST_CALC,
        ST_DONE
    } state_e;

    // number of operand bytes following the opcode
    function automatic logic [1:0] operand_bytes(logic [MODE_W-1:0] m);
        case (m)
            M_ZP, M_ZPX, M_ZPY, M_INDX, M_INDY, M_REL: operand_bytes = 2'd1;
            M_ABS, M_ABSX, M_ABSY, M_IND:              operand_bytes = 2'd2;
            default:                                   operand_bytes = 2'd0;
        endcase
    endfunction

    // modes that dereference a two-byte pointer
    function automatic logic uses_pointer(logic [MODE_W-1:0] m);
        uses_pointer = (m == M_INDX) || (m == M_INDY) || (m == M_IND);
    endfunction

endpackage

// File: rtl/oau_idx_add.sv
module oau_idx_add #(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [BYTE_W-1:0] idx,
    input  logic              sign_en,
    output logic [ADDR_W-1:0] sum,
    output logic              crossed
);
    localparam int HI_W = ADDR_W - BYTE_W;

    logic [ADDR_W-1:0] idx_ext;

    always_comb begin
        idx_ext = {{HI_W{idx[BYTE_W-1] & sign_en}}, idx};
        sum     = base + idx_ext;
        crossed = (sum[ADDR_W-1:BYTE_W] != base[ADDR_W-1:BYTE_W]);
    end
endmodule

// File: rtl/oau_ptr_addr.sv
module oau_ptr_addr #(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] op_lo,
    input  logic [BYTE_W-1:0] op_hi,
    input  logic [BYTE_W-1:0] x_val,
    input  logic              add_x,
    input  logic              vec_mode,
    output logic [ADDR_W-1:0] lo_addr,
    output logic [ADDR_W-1:0] hi_addr
);
    localparam int HI_W = ADDR_W - BYTE_W;

    logic [BYTE_W-1:0] p_lo;
    logic [BYTE_W-1:0] p_next;
    logic [HI_W-1:0]   p_page;

    always_comb begin
        p_lo    = add_x ? (op_lo + x_val) : op_lo;
        // the second byte never carries into the page: wraps inside it
        p_next  = p_lo + BYTE_W'(1);
        p_page  = vec_mode ? HI_W'(op_hi) : '0;
        lo_addr = {p_page, p_lo};
        hi_addr = {p_page, p_next};
    end

    always_comb begin
        if (!vec_mode)
            assert_zp_pointer_R6: assert (hi_addr[ADDR_W-1:BYTE_W] == '0);
    end
endmodule

// File: rtl/oau_top.sv
module oau_top
    import oau_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [3:0]        mode,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [7:0]        x_idx,
    input  logic [7:0]        y_idx,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [7:0]        mem_rdata,
    output logic [ADDR_W-1:0] ea,
    output logic              page_cross,
    output logic [ADDR_W-1:0] pc_out,
    output logic              done
);
    localparam int BYTE_W = ADDR_W / 2;
    localparam int HI_W   = ADDR_W - BYTE_W;

    state_e            state, state_nx;
    logic [3:0]        mode_q;
    logic [ADDR_W-1:0] pc_q;
    logic [BYTE_W-1:0] x_q, y_q;
    logic [BYTE_W-1:0] op_lo, op_hi, ptr_lo, ptr_hi;
    logic [ADDR_W-1:0] ea_q, pc_out_q;
    logic              cross_q;

    logic [1:0]        nbytes;
    logic              has_ptr;
    logic [ADDR_W-1:0] ptr_lo_addr, ptr_hi_addr;

    logic [ADDR_W-1:0] add_base, add_sum;
    logic [BYTE_W-1:0] add_idx;
    logic              add_signed, add_cross;

    logic [ADDR_W-1:0] ea_nx, pc_nx;
    logic              cross_nx;

    assign nbytes  = operand_bytes(state == ST_IDLE ? mode : mode_q);
    assign has_ptr = uses_pointer(mode_q);

    oau_ptr_addr #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_ptr (
        .op_lo    (op_lo),
        .op_hi    (op_hi),
        .x_val    (x_q),
        .add_x    (mode_q == M_INDX),
        .vec_mode (mode_q == M_IND),
        .lo_addr  (ptr_lo_addr),
        .hi_addr  (ptr_hi_addr)
    );

    oau_idx_add #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_add (
        .base    (add_base),
        .idx     (add_idx),
        .sign_en (add_signed),
        .sum     (add_sum),
        .crossed (add_cross)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (start) state_nx = (nbytes == 2'd0) ? ST_CALC : ST_OPL_REQ;
            ST_OPL_REQ:  state_nx = ST_OPL_WAIT;
            ST_OPL_WAIT: begin
                if (nbytes == 2'd2)  state_nx = ST_OPH_REQ;
                else if (has_ptr)    state_nx = ST_PTL_REQ;
                else                 state_nx = ST_CALC;
            end
            ST_OPH_REQ:  state_nx = ST_OPH_WAIT;
            ST_OPH_WAIT: state_nx = has_ptr ? ST_PTL_REQ : ST_CALC;
            ST_PTL_REQ:  state_nx = ST_PTL_WAIT;
            ST_PTL_WAIT: state_nx = ST_PTH_REQ;
            ST_PTH_REQ:  state_nx = ST_PTH_WAIT;
            ST_PTH_WAIT: state_nx = ST_CALC;
            ST_CALC:     state_nx = ST_DONE;
            ST_DONE:     state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // ---------------- output process ----------------
    always_comb begin
        mem_rd   = 1'b0;
        mem_addr = '0;
        unique case (state)
            ST_OPL_REQ: begin mem_rd = 1'b1; mem_addr = pc_q; end
            ST_OPH_REQ: begin mem_rd = 1'b1; mem_addr = pc_q + ADDR_W'(1); end
            ST_PTL_REQ: begin mem_rd = 1'b1; mem_addr = ptr_lo_addr; end
            ST_PTH_REQ: begin mem_rd = 1'b1; mem_addr = ptr_hi_addr; end
            default: ;
        endcase
        done       = (state == ST_DONE);
        ea         = ea_q;
        pc_out     = pc_out_q;
        page_cross = cross_q;
    end

    // ---------------- final address computation ----------------
    always_comb begin
        add_base   = {op_hi, op_lo};
        add_idx    = x_q;
        add_signed = 1'b0;
        case (mode_q)
            M_ABSY: add_idx = y_q;
            M_INDY: begin add_base = {ptr_hi, ptr_lo}; add_idx = y_q; end
            M_REL:  begin add_base = pc_q + ADDR_W'(1); add_idx = op_lo; add_signed = 1'b1; end
            default: ;
        endcase
    end

    always_comb begin
        ea_nx    = '0;
        pc_nx    = pc_q;
        cross_nx = 1'b0;
        case (mode_q)
            M_IMM:  begin ea_nx = pc_q; pc_nx = pc_q + ADDR_W'(1); end
            M_ZP:   begin ea_nx = {{HI_W{1'b0}}, op_lo}; pc_nx = pc_q + ADDR_W'(1); end
            M_ZPX:  begin ea_nx = {{HI_W{1'b0}}, BYTE_W'(op_lo + x_q)}; pc_nx = pc_q + ADDR_W'(1); end
            M_ZPY:  begin ea_nx = {{HI_W{1'b0}}, BYTE_W'(op_lo + y_q)}; pc_nx = pc_q + ADDR_W'(1); end
            M_ABS:  begin ea_nx = {op_hi, op_lo}; pc_nx = pc_q + ADDR_W'(2); end
            M_ABSX, M_ABSY: begin
                ea_nx = add_sum; cross_nx = add_cross; pc_nx = pc_q + ADDR_W'(2);
            end
            M_INDX: begin ea_nx = {ptr_hi, ptr_lo}; pc_nx = pc_q + ADDR_W'(1); end
            M_INDY: begin ea_nx = add_sum; cross_nx = add_cross; pc_nx = pc_q + ADDR_W'(1); end
            M_IND:  begin ea_nx = {ptr_hi, ptr_lo}; pc_nx = pc_q + ADDR_W'(2); end
            M_REL:  begin ea_nx = add_sum; cross_nx = add_cross; pc_nx = pc_q + ADDR_W'(1); end
            default: ;
        endcase
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= '0;
            pc_q     <= '0;
            x_q      <= '0;
            y_q      <= '0;
            op_lo    <= '0;
            op_hi    <= '0;
            ptr_lo   <= '0;
            ptr_hi   <= '0;
            ea_q     <= '0;
            pc_out_q <= '0;
            cross_q  <= 1'b0;
        end else begin
            if (state == ST_IDLE && start) begin
                mode_q <= mode;
                pc_q   <= pc_in;
                x_q    <= x_idx;
                y_q    <= y_idx;
                op_hi  <= '0;
            end
            if (state == ST_OPL_WAIT) op_lo  <= mem_rdata;
            if (state == ST_OPH_WAIT) op_hi  <= mem_rdata;
            if (state == ST_PTL_WAIT) ptr_lo <= mem_rdata;
            if (state == ST_PTH_WAIT) ptr_hi <= mem_rdata;
            if (state == ST_CALC) begin
                ea_q     <= ea_nx;
                pc_out_q <= pc_nx;
                cross_q  <= cross_nx;
            end
        end
    end

    // ---------------- assertions ----------------
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_start_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> $stable(mode_q) && $stable(pc_q));

    assert_rd_spacing_R12: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);

    assert_zp_range_R3: assert property (@(posedge clk) disable iff (rst)
        (done && (mode_q == M_ZP || mode_q == M_ZPX || mode_q == M_ZPY))
            |-> (ea[ADDR_W-1:BYTE_W] == '0) && !page_cross);

    assert_indx_nocross_R6: assert property (@(posedge clk) disable iff (rst)
        (done && mode_q == M_INDX) |-> !page_cross);

    assert_vec_page_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PTH_REQ && mode_q == M_IND) |-> mem_addr[ADDR_W-1:BYTE_W] == op_hi);

    assert_unused_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CALC && mode_q > 4'd10) |-> !$past(mem_rd));

endmodule

// File: tb/oau_top_test.sv
`timescale 1ns/1ps
module oau_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [15:0] pc_in = '0;
    logic [7:0]  x_idx = '0, y_idx = '0;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_rdata = '0;
    logic [15:0] ea, pc_out;
    logic        page_cross, done;

    int checks = 0;
    int errors = 0;

    // sparse memory model
    logic [15:0] ov_addr [16];
    logic [7:0]  ov_data [16];
    int          ov_n = 0;

    // read log
    logic [15:0] rd_log [64];
    int          nrd = 0;

    // result of the last run
    int          lat;
    int          rd0;

    always #4 clk = ~clk;

    oau_top uut (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .pc_in(pc_in),
        .x_idx(x_idx), .y_idx(y_idx), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata), .ea(ea), .page_cross(page_cross),
        .pc_out(pc_out), .done(done)
    );

    function automatic logic [7:0] mem_byte(logic [15:0] a);
        logic [7:0] d;
        d = a[7:0] ^ a[15:8] ^ 8'h5A;
        for (int i = 0; i < ov_n; i++)
            if (ov_addr[i] == a) d = ov_data[i];
        return d;
    endfunction

    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= mem_byte(mem_addr);
            if (nrd < 64) rd_log[nrd] <= mem_addr;
            nrd <= nrd + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [15:0] a, input logic [7:0] d);
        ov_addr[ov_n] = a;
        ov_data[ov_n] = d;
        ov_n++;
    endtask

    task automatic run(input logic [3:0] m, input logic [15:0] pc, input logic [7:0] xv, input logic [7:0] yv);
        @(negedge clk);
        rd0   = nrd;
        mode  = m; pc_in = pc; x_idx = xv; y_idx = yv;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        if (!done) chk(1'b0, "timeout", 32'(lat), 32'd0);
    endtask

    task automatic expect_res(input string tag, input logic [15:0] e_ea, input logic [15:0] e_pc,
                              input bit e_cr, input int e_lat);
        chk(ea == e_ea, {tag, " ea"}, 32'(ea), 32'(e_ea));
        chk(pc_out == e_pc, {tag, " pc_out"}, 32'(pc_out), 32'(e_pc));
        chk(page_cross == e_cr, {tag, " page_cross"}, 32'(page_cross), 32'(e_cr));
        chk(lat == e_lat, {tag, " latency"}, 32'(lat), 32'(e_lat));
        @(negedge clk);
        chk(done == 1'b0, "R11 done width", 32'(done), 32'd0);
    endtask

    task automatic expect_reads(input string tag, input int n, input logic [15:0] a0,
                                input logic [15:0] a1, input logic [15:0] a2, input logic [15:0] a3);
        logic [15:0] want [4];
        want[0] = a0; want[1] = a1; want[2] = a2; want[3] = a3;
        chk(nrd - rd0 == n, {tag, " R12 read count"}, 32'(nrd - rd0), 32'(n));
        for (int i = 0; i < n && i < 4; i++)
            chk(rd_log[rd0 + i] == want[i], {tag, " R12 read addr"}, 32'(rd_log[rd0 + i]), 32'(want[i]));
    endtask

    task automatic t_reset_R1();
        @(negedge clk);
        chk(done == 0, "R1 done", 32'(done), 0);
        chk(page_cross == 0, "R1 page_cross", 32'(page_cross), 0);
        chk(mem_rd == 0, "R1 mem_rd", 32'(mem_rd), 0);
        chk(ea == 0, "R1 ea", 32'(ea), 0);
        chk(pc_out == 0, "R1 pc_out", 32'(pc_out), 0);
    endtask

    task automatic t_imm_R2();
        run(4'd0, 16'h1234, 8'h00, 8'h00);
        expect_reads("R2", 0, 0, 0, 0, 0);
        expect_res("R2 imm", 16'h1234, 16'h1235, 1'b0, 2);
    endtask

    task automatic t_zp_R3();
        ov_n = 0;
        poke(16'h0300, 8'h80); poke(16'h0400, 8'hF0); poke(16'h0410, 8'h33);
        run(4'd1, 16'h0300, 8'h11, 8'h22);
        expect_reads("R3 zp", 1, 16'h0300, 0, 0, 0);
        expect_res("R3 zp", 16'h0080, 16'h0301, 1'b0, 4);
        run(4'd2, 16'h0400, 8'h20, 8'h00);
        expect_res("R3 zpx wrap", 16'h0010, 16'h0401, 1'b0, 4);
        run(4'd3, 16'h0410, 8'hFF, 8'h05);
        expect_res("R3 zpy", 16'h0038, 16'h0411, 1'b0, 4);
    endtask

    task automatic t_abs_R4();
        ov_n = 0;
        poke(16'h0500, 8'h34); poke(16'h0501, 8'h12);
        run(4'd4, 16'h0500, 8'h00, 8'h00);
        expect_reads("R4 abs", 2, 16'h0500, 16'h0501, 0, 0);
        expect_res("R4 abs", 16'h1234, 16'h0502, 1'b0, 6);
    endtask

    task automatic t_absidx_R5();
        ov_n = 0;
        poke(16'h0600, 8'hF0); poke(16'h0601, 8'h12);
        poke(16'h0610, 8'h00); poke(16'h0611, 8'h12);
        run(4'd5, 16'h0600, 8'h20, 8'h01);
        expect_res("R5 absx cross", 16'h1310, 16'h0602, 1'b1, 6);
        run(4'd6, 16'h0610, 8'h80, 8'h05);
        expect_res("R5 absy same page", 16'h1205, 16'h0612, 1'b0, 6);
    endtask

    task automatic t_indx_R6();
        ov_n = 0;
        poke(16'h0700, 8'hFE); poke(16'h00FF, 8'h78); poke(16'h0000, 8'h56);
        run(4'd7, 16'h0700, 8'h01, 8'h00);
        expect_reads("R6 indx wrap", 3, 16'h0700, 16'h00FF, 16'h0000, 0);
        expect_res("R6 indx", 16'h5678, 16'h0701, 1'b0, 8);
    endtask

    task automatic t_indy_R7();
        ov_n = 0;
        poke(16'h0800, 8'hFF); poke(16'h00FF, 8'hF0); poke(16'h0000, 8'h12);
        run(4'd8, 16'h0800, 8'h00, 8'h20);
        expect_reads("R7 indy wrap", 3, 16'h0800, 16'h00FF, 16'h0000, 0);
        expect_res("R7 indy cross", 16'h1310, 16'h0801, 1'b1, 8);
        ov_n = 0;
        poke(16'h0800, 8'h40); poke(16'h0040, 8'h00); poke(16'h0041, 8'h30);
        run(4'd8, 16'h0800, 8'h00, 8'h10);
        expect_res("R7 indy no cross", 16'h3010, 16'h0801, 1'b0, 8);
    endtask

    task automatic t_ind_R8();
        ov_n = 0;
        poke(16'h0900, 8'hFF); poke(16'h0901, 8'h02);
        poke(16'h02FF, 8'hCD); poke(16'h0200, 8'hAB); poke(16'h0300, 8'hEE);
        run(4'd9, 16'h0900, 8'h00, 8'h00);
        expect_reads("R8 vector FF", 4, 16'h0900, 16'h0901, 16'h02FF, 16'h0200);
        expect_res("R8 vector FF", 16'hABCD, 16'h0902, 1'b0, 10);
        ov_n = 0;
        poke(16'h0900, 8'h10); poke(16'h0901, 8'h03);
        poke(16'h0310, 8'h11); poke(16'h0311, 8'h22);
        run(4'd9, 16'h0900, 8'h00, 8'h00);
        expect_reads("R8 vector", 4, 16'h0900, 16'h0901, 16'h0310, 16'h0311);
        expect_res("R8 vector", 16'h2211, 16'h0902, 1'b0, 10);
    endtask

    task automatic t_rel_R9();
        ov_n = 0;
        poke(16'h0A00, 8'h05); poke(16'h0B00, 8'h80); poke(16'h0CF0, 8'h20);
        run(4'd10, 16'h0A00, 8'h00, 8'h00);
        expect_res("R9 rel fwd", 16'h0A06, 16'h0A01, 1'b0, 4);
        run(4'd10, 16'h0B00, 8'h00, 8'h00);
        expect_res("R9 rel back cross", 16'h0A81, 16'h0B01, 1'b1, 4);
        run(4'd10, 16'h0CF0, 8'h00, 8'h00);
        expect_res("R9 rel fwd cross", 16'h0D11, 16'h0CF1, 1'b1, 4);
    endtask

    task automatic t_unused_R10();
        run(4'd13, 16'h4444, 8'h01, 8'h01);
        expect_reads("R10", 0, 0, 0, 0, 0);
        expect_res("R10 code 13", 16'h0000, 16'h4444, 1'b0, 2);
        run(4'd15, 16'h0101, 8'h00, 8'h00);
        expect_res("R10 code 15", 16'h0000, 16'h0101, 1'b0, 2);
    endtask

    task automatic t_busy_start_R11();
        int quiet;
        ov_n = 0;
        poke(16'h0500, 8'h34); poke(16'h0501, 8'h12);
        @(negedge clk);
        rd0 = nrd;
        mode = 4'd4; pc_in = 16'h0500; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        mode = 4'd0; pc_in = 16'h7777; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 3;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        expect_res("R11 busy start", 16'h1234, 16'h0502, 1'b0, 6);
        quiet = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (done) quiet++;
        end
        chk(quiet == 0, "R11 no queued op", 32'(quiet), 32'd0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset_R1();
        t_imm_R2();
        t_zp_R3();
        t_abs_R4();
        t_absidx_R5();
        t_indx_R6();
        t_indy_R7();
        t_ind_R8();
        t_rel_R9();
        t_unused_R10();
        t_busy_start_R11();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule